// File: doc/BRIEF.md
# Read-Set Mark Tracker

This block keeps, for one hardware thread, a single mark bit for each cache block that a software transaction has already logged in its read set. Before adding a block to the read set, the transaction's read barrier sends a check-and-set request with the block address. One cycle later the block answers whether that block was already marked and undisturbed since marking. In the same operation it sets the mark, so the barrier can skip a block it has already logged.

The marks follow the lifetime of the cache lines and are not plain stored flags. A snoop input reports a block that leaves the cache or is written by another thread. When such a block carries a mark, the mark drops without notice and a sticky "marks lost" flag goes high. Allocating a new block over a marked entry has the same effect. A context switch wipes every mark and raises the flag. Software asks, with a one-cycle query, whether anything may have been lost. It then decides between trusting the marks and running full read-set validation. A clear command starts a new transaction with no marks and a low flag.

Block addresses sit in a small fully associative table. Each entry holds a tag, a valid bit and a mark bit, and entries are replaced in round-robin order.

Top module: `rdset_mark_tracker`

## Requirements
- R1: After reset no block is marked, the marks-lost flag is 0, and both response strobes are low.
- R2: A check-and-set on a block that is not marked answers was-marked = 0 and marks the block. A later check-and-set on the same block, with no disturbance in between, answers 1.
- R3: A check-and-set or a query raised in cycle N produces its response strobe, and its result, in cycle N+1 only. The strobe is low in every cycle that follows no request.
- R4: A snoop that hits a marked block unmarks it and sets the marks-lost flag. The next check-and-set on that block answers 0.
- R5: A snoop to a block that is not in the table, or that is in the table but unmarked, leaves the marks-lost flag unchanged.
- R6: The table holds ENTRIES blocks (default 16). A check-and-set that misses allocates the entry at a round-robin pointer, which starts at entry 0 and advances only on allocation. If the replaced entry was marked, the marks-lost flag is set.
- R7: A query answers the marks-lost flag as it stood in the request cycle, before that cycle's updates take effect.
- R8: Once set, the marks-lost flag stays set through any traffic until a clear.
- R9: A context-switch pulse unmarks every block and sets the marks-lost flag. A check-and-set in the same cycle answers 0 and leaves the block unmarked.
- R10: A clear unmarks every block and lowers the marks-lost flag in one cycle. It wins over a context switch in the same cycle. A check-and-set in the same cycle answers 0 and leaves the block unmarked. Table contents and valid bits are kept.
- R11: A check-and-set and a snoop to the same block in the same cycle: the check answers 0, and afterwards the block is neither marked nor held in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Check-and-set request pulse |
| chk_block | input | BLOCK_W | Block address of the check-and-set |
| chk_done | output | 1 | Check-and-set response strobe |
| chk_was_marked | output | 1 | 1 if the block was marked and undisturbed |
| snoop_valid | input | 1 | Eviction or remote-write report pulse |
| snoop_block | input | BLOCK_W | Block address of the snoop |
| ctx_switch | input | 1 | Context-switch pulse |
| clear | input | 1 | Drop all marks and lower the flag |
| query_valid | input | 1 | Marks-lost query pulse |
| query_done | output | 1 | Query response strobe |
| query_lost | output | 1 | Marks-lost flag at the time of the query |

## Verification
The hardest condition to reach from the ports is losing a mark through capacity: a marked entry being pushed out by round-robin allocation. It only occurs after more distinct blocks than the table holds have been checked. The stimulus first fills all sixteen entries with marked blocks and then checks a seventeenth, and a long run of random traffic over twenty addresses keeps recycling entries. The same-cycle collisions between check, snoop, clear and context switch are driven deliberately. Every response is compared with a model of the table that the bench holds.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  // One-cycle response: strobe plus a single result bit
  typedef struct packed {
    logic done;
    logic bit_out;
  } rmt_resp_t;
endpackage

// File: rtl/rmt_tag_match.sv
module rmt_tag_match #(
  parameter int BLOCK_W = 26,
  parameter int ENTRIES = 16
) (
  input  logic [BLOCK_W-1:0] tags [ENTRIES],
  input  logic [ENTRIES-1:0] valid,
  input  logic [BLOCK_W-1:0] key,
  output logic [ENTRIES-1:0] match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/rmt_rr_victim.sv
module rmt_rr_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (advance) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  p_ptr_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    32'(ptr_q) < ENTRIES);
endmodule

// File: rtl/rdset_mark_tracker.sv
module rdset_mark_tracker
  import rmt_pkg::*;
#(
  parameter int BLOCK_W = 26,
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk_valid,
  input  logic [BLOCK_W-1:0] chk_block,
  output logic               chk_done,
  output logic               chk_was_marked,
  input  logic               snoop_valid,
  input  logic [BLOCK_W-1:0] snoop_block,
  input  logic               ctx_switch,
  input  logic               clear,
  input  logic               query_valid,
  output logic               query_done,
  output logic               query_lost
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [BLOCK_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, mark_q;
  logic               lost_q;
  rmt_resp_t          chk_resp_q, qry_resp_q;

  logic [ENTRIES-1:0] chk_match, snp_match, snp_hit, victim_oh;
  logic [IDX_W-1:0]   victim;
  logic               same_blk, chk_eff, chk_hit, alloc;
  logic               was_marked_c, snoop_loss, evict_loss;

  rmt_tag_match #(.BLOCK_W(BLOCK_W), .ENTRIES(ENTRIES)) u_chk_match (
    .tags(tag_q), .valid(vld_q), .key(chk_block), .match(chk_match));

  rmt_tag_match #(.BLOCK_W(BLOCK_W), .ENTRIES(ENTRIES)) u_snp_match (
    .tags(tag_q), .valid(vld_q), .key(snoop_block), .match(snp_match));

  rmt_rr_victim #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst(rst), .advance(alloc), .ptr(victim));

  // A check colliding with clear, a context switch or a same-block snoop does nothing
  assign same_blk     = chk_valid && snoop_valid && (chk_block == snoop_block);
  assign chk_eff      = chk_valid && !clear && !ctx_switch && !same_blk;
  assign chk_hit      = |chk_match;
  assign alloc        = chk_eff && !chk_hit;
  assign snp_hit      = snp_match & {ENTRIES{snoop_valid}};
  assign was_marked_c = chk_eff && |(chk_match & mark_q);
  assign snoop_loss   = |(snp_hit & mark_q);
  assign evict_loss   = |(victim_oh & mark_q);

  always_comb begin
    victim_oh = '0;
    if (alloc) victim_oh[victim] = 1'b1;
  end

  // Tag store: written only on allocation, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      if (victim_oh[i]) tag_q[i] <= chk_block;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      mark_q <= '0;
      lost_q <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim_oh[i])     vld_q[i] <= 1'b1;
        else if (snp_hit[i])  vld_q[i] <= 1'b0;

        if (clear || ctx_switch)                mark_q[i] <= 1'b0;
        else if (victim_oh[i])                  mark_q[i] <= 1'b1;
        else if (chk_eff && chk_match[i])       mark_q[i] <= 1'b1;
        else if (snp_hit[i])                    mark_q[i] <= 1'b0;
      end
      if (clear) lost_q <= 1'b0;
      else if (ctx_switch || snoop_loss || evict_loss) lost_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_resp_q <= '0;
      qry_resp_q <= '0;
    end else begin
      chk_resp_q <= '{done: chk_valid, bit_out: was_marked_c};
      qry_resp_q <= '{done: query_valid, bit_out: query_valid && lost_q};
    end
  end

  assign chk_done       = chk_resp_q.done;
  assign chk_was_marked = chk_resp_q.bit_out;
  assign query_done     = qry_resp_q.done;
  assign query_lost     = qry_resp_q.bit_out;

  p_resp_next_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done);
  p_unique_tags_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_match));
  p_mark_implies_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (mark_q & ~vld_q) == '0);
  p_clear_wipes_r10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!lost_q && $countones(mark_q) == 0));
  p_ctx_wipes_r9: assert property (@(posedge clk) disable iff (rst)
    (ctx_switch && !clear) |=> (lost_q && $countones(mark_q) == 0));
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (lost_q && !clear) |=> lost_q);
  p_query_old_value_r7: assert property (@(posedge clk) disable iff (rst)
    query_valid |=> (query_done && query_lost == $past(lost_q)));
endmodule

// File: tb/test_rdset_mark_tracker.sv
module test_rdset_mark_tracker;
  localparam int AW = 26;
  localparam int N  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk_valid = 1'b0, snoop_valid = 1'b0, ctx_switch = 1'b0, clear = 1'b0, query_valid = 1'b0;
  logic [AW-1:0] chk_block = '0, snoop_block = '0;
  logic chk_done, chk_was_marked, query_done, query_lost;

  always #10 clk = ~clk;

  rdset_mark_tracker #(.BLOCK_W(AW), .ENTRIES(N)) i_rdset_mark_tracker (
    .clk(clk), .rst(rst),
    .chk_valid(chk_valid), .chk_block(chk_block),
    .chk_done(chk_done), .chk_was_marked(chk_was_marked),
    .snoop_valid(snoop_valid), .snoop_block(snoop_block),
    .ctx_switch(ctx_switch), .clear(clear),
    .query_valid(query_valid), .query_done(query_done), .query_lost(query_lost));

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // Bench-side model of the requirements
  logic [AW-1:0] mtag [N];
  bit mvld [N];
  bit mmark [N];
  int mrr = 0;
  bit mlost = 0;

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks at the next falling edge
  task automatic step(input bit dc, input logic [AW-1:0] ca, input bit ds, input logic [AW-1:0] sa,
                      input bit dq, input bit dx, input bit dl, input string req);
    bit same, eff, sloss, eloss, exp_flag, exp_q;
    int hit, shit;
    same = dc && ds && (ca == sa);
    eff = dc && !dl && !dx && !same;
    exp_q = dq && mlost;
    hit = -1; shit = -1;
    for (int i = 0; i < N; i++) begin
      if (mvld[i] && mtag[i] == ca) hit = i;
      if (ds && mvld[i] && mtag[i] == sa) shit = i;
    end
    exp_flag = eff && hit >= 0 && mmark[hit];
    sloss = shit >= 0 && mmark[shit];
    eloss = 0;
    if (shit >= 0) begin mvld[shit] = 0; mmark[shit] = 0; end
    if (eff) begin
      if (hit >= 0) mmark[hit] = 1;
      else begin
        eloss = mmark[mrr];
        mtag[mrr] = ca; mvld[mrr] = 1; mmark[mrr] = 1;
        mrr = (mrr + 1) % N;
      end
    end
    if (dl || dx) for (int i = 0; i < N; i++) mmark[i] = 0;
    if (dl) mlost = 0;
    else if (dx || sloss || eloss) mlost = 1;

    chk_valid = dc; chk_block = ca; snoop_valid = ds; snoop_block = sa;
    query_valid = dq; ctx_switch = dx; clear = dl;
    @(negedge clk);
    chk_valid = 0; snoop_valid = 0; query_valid = 0; ctx_switch = 0; clear = 0;
    check1(req, "chk_done", chk_done, dc);
    if (dc) check1(req, "chk_was_marked", chk_was_marked, exp_flag);
    check1(req, "query_done", query_done, dq);
    if (dq) check1(req, "query_lost", query_lost, exp_q);
  endtask

  task automatic chk(input logic [AW-1:0] a, input string req); step(1, a, 0, 0, 0, 0, 0, req); endtask
  task automatic snp(input logic [AW-1:0] a, input string req); step(0, 0, 1, a, 0, 0, 0, req); endtask
  task automatic qry(input string req); step(0, 0, 0, 0, 1, 0, 0, req); endtask
  task automatic idle(input string req); step(0, 0, 0, 0, 0, 0, 0, req); endtask
  task automatic clr(input string req); step(0, 0, 0, 0, 0, 0, 1, req); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mvld[i] = 0; mmark[i] = 0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check1("R1", "chk_done", chk_done, 0);
    check1("R1", "query_done", query_done, 0);
    qry("R1");
    chk(26'd5, "R1");
    // R2: repeat check answers 1
    chk(26'd5, "R2");
    chk(26'd6, "R2");
    chk(26'd6, "R2");
    // R3: no strobe without request
    idle("R3");
    idle("R3");
    // R4: snoop on marked block
    snp(26'd5, "R4");
    qry("R4");
    chk(26'd5, "R4");
    // R10: clear
    clr("R10");
    qry("R10");
    // R5: snoop to absent block, then to a held but unmarked block
    snp(26'd999, "R5");
    qry("R5");
    snp(26'd6, "R5");
    qry("R5");
    // R6: fill all entries, then overflow
    clr("R6");
    for (int i = 0; i < N; i++) chk(26'(100 + i), "R6");
    for (int i = 0; i < N; i++) chk(26'(100 + i), "R6");
    qry("R6");
    chk(26'd200, "R6");
    qry("R6");
    for (int i = 0; i < N; i++) chk(26'(100 + i), "R6");
    // R7: query alongside a loss returns the prior value
    clr("R7");
    chk(26'd300, "R7");
    step(0, 0, 1, 26'd300, 1, 0, 0, "R7");
    qry("R7");
    // R8: sticky through traffic
    chk(26'd301, "R8");
    idle("R8");
    snp(26'd999, "R8");
    qry("R8");
    // R9: context switch
    clr("R9");
    chk(26'd400, "R9");
    step(0, 0, 0, 0, 1, 1, 0, "R9");
    qry("R9");
    chk(26'd400, "R9");
    step(1, 26'd400, 0, 0, 0, 1, 0, "R9");
    chk(26'd400, "R9");
    // R10: clear beats check and ctx
    chk(26'd401, "R10");
    step(1, 26'd401, 0, 0, 0, 0, 1, "R10");
    chk(26'd401, "R10");
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    qry("R10");
    // R11: check and snoop on same block
    chk(26'd500, "R11");
    step(1, 26'd500, 1, 26'd500, 0, 0, 0, "R11");
    chk(26'd500, "R11");
    step(1, 26'd501, 1, 26'd501, 0, 0, 0, "R11");
    chk(26'd501, "R11");
    qry("R11");
    // Random traffic over a small address pool against the model
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 1023);
      step(r[1:0] != 0, 26'($urandom_range(0, 19)), r[3:2] == 0, 26'($urandom_range(0, 19)),
           r[4], r[9:5] == 0, r[9:5] == 1, "R2");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule